// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. After reset it drives the command pins through the fixed start-up sequence a DDR device needs. The order is: a long quiet wait, precharge of all banks, the extended mode write that enables the DLL, a mode write that also resets the DLL, a second precharge of all banks, two or more auto-refreshes, a final mode write that clears the DLL reset request, and a lockout. Once all of these are complete it raises a done flag.

Every wait is a count of clock cycles set by a parameter. The mode op-codes are parameters as well. The bus is idle until reset is released, and it carries nothing but no-operation commands after done. A normal controller takes over the pins once done is high.

The clock is assumed to be stable when reset is released. Supply ramping, reference voltage and clock stability detection are handled elsewhere.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and from the first clock edge on which it is sampled high, CKE is low, done is low and the command pins {cs_n, ras_n, cas_n, we_n} read 1111 (deselect).
- R2: From the first cycle after reset is released, the pins carry no-operation {0,1,1,1} for exactly STABLE_CYC cycles.
- R3: Precharge-all is {0,0,1,0} with address bit 10 set, all other address bits zero and bank 00. It is issued once when the stable wait ends, and again tMRD cycles after the DLL-reset mode write.
- R4: The extended mode write is {0,0,0,0} with bank 01 and the address EMR_OP with bit 0 forced to 0 (DLL enabled). It is issued TRP_CYC cycles after the first precharge-all.
- R5: The DLL-reset mode write is {0,0,0,0} with bank 00 and the address MR_OP with bit 8 forced to 1. It is issued TMRD_CYC cycles after the extended mode write.
- R6: The gap between two consecutive commands is exactly the wait belonging to the earlier one: TRP_CYC after a precharge, TMRD_CYC after a mode write, TRFC_CYC after a refresh. Every cycle in between is a no-operation.
- R7: Auto-refresh is {0,0,0,1} with bank 00 and address zero. It is issued max(REF_CNT,2) times, the first TRP_CYC cycles after the second precharge-all.
- R8: The final mode write is {0,0,0,0} with bank 00 and the address MR_OP with bit 8 forced to 0. It is issued TRFC_CYC cycles after the last refresh.
- R9: Done first reads high in cycle max(t_final + TMRD_CYC, t_dll + LOCK_CYC), where t_final and t_dll are the cycles of the final and DLL-reset mode writes. Done stays high until reset, and the pins carry only no-operations while it is high.
- R10: CKE stays high in every cycle from reset release onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / op-code |
| done_o | output | 1 | Initialization complete |

## Verification
Two instances run side by side with different parameter sets. In the first, the lockout outlasts the rest of the sequence, the refresh count is above the minimum, and the extended op-code has bit 0 set. In the second, tMRD after the final mode write decides when done rises, a refresh count of 1 must be raised to 2, and the mode op-code has bit 8 set, so both DLL-bit forcings are exercised in each direction. Every command is compared on its exact cycle, code, bank and address, which separates an ordering mistake from an off-by-one in any single wait. A reset applied after done shows that the pins return to the idle state.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL,
      CMD_NOP,
      CMD_PREA,
      CMD_REF,
      CMD_MODE
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STABLE,
      ST_PREA1,
      ST_EMRS,
      ST_MRS_DLL,
      ST_PREA2,
      ST_REF,
      ST_MRS_FIN,
      ST_WAIT,
      ST_DONE
   } state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic [W-1:0] cnt,
   output logic         expired
);

   always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (load)          cnt <= val;
      else if (cnt != '0)     cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

   // R6
   timer_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
   parameter int W        = 8,
   parameter int LOAD_VAL = 198
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   output logic [W-1:0] left
);

   always_ff @(posedge clk) begin
      if (rst)                left <= '0;
      else if (start)         left <= W'(LOAD_VAL);
      else if (left != '0)    left <= left - W'(1);
   end

   // R9
   lock_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (!start && left != '0) |=> (left == $past(left) - W'(1)));

   // R9
   lock_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (!start && left == '0) |=> (left == '0));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
(
   input  cmd_e cmd,
   output logic cs_n,
   output logic ras_n,
   output logic cas_n,
   output logic we_n
);

   always_comb begin
      unique case (cmd)
         CMD_NOP:  {cs_n, ras_n, cas_n, we_n} = 4'b0111;
         CMD_PREA: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
         CMD_REF:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
         CMD_MODE: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
         default:  {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      endcase
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                BA_W       = 2,
   parameter int                STABLE_CYC = 20000,
   parameter int                TRP_CYC    = 2,
   parameter int                TMRD_CYC   = 2,
   parameter int                TRFC_CYC   = 8,
   parameter int                REF_CNT    = 2,
   parameter int                LOCK_CYC   = 200,
   parameter logic [ADDR_W-1:0] EMR_OP     = '0,
   parameter logic [ADDR_W-1:0] MR_OP      = ADDR_W'('h062)
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              done_o
);

   localparam int REF_N = (REF_CNT < 2) ? 2 : REF_CNT;
   localparam int RN_W  = $clog2(REF_N + 1);
   localparam int MAXC  = umax(umax(STABLE_CYC, LOCK_CYC),
                               umax(TRFC_CYC, umax(TRP_CYC, TMRD_CYC)));
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int A_DLL = 8;
   localparam int A_ALL = 10;

   if (ADDR_W < 11 || BA_W < 2 || STABLE_CYC < 1 || TRP_CYC < 2 ||
       TMRD_CYC < 2 || TRFC_CYC < 2 || LOCK_CYC < 2) begin : g_bad_param
      $error("ddr_init_seq: parameter out of range");
   end

   state_e            st, st_n, ret, ret_n;
   logic [RN_W-1:0]   rleft, rleft_n;
   logic              t_load, t_exp, lk_start;
   logic [CNT_W-1:0]  t_val, t_cnt, lk_left;
   cmd_e              cmd;

   always_comb begin
      st_n     = st;
      ret_n    = ret;
      rleft_n  = rleft;
      t_load   = 1'b0;
      t_val    = '0;
      lk_start = 1'b0;
      cmd      = CMD_NOP;
      ba_o     = '0;
      addr_o   = '0;
      unique case (st)
         ST_IDLE: begin
            cmd    = CMD_DESEL;
            st_n   = ST_STABLE;
            t_load = 1'b1;
            t_val  = CNT_W'(STABLE_CYC - 1);
         end
         ST_STABLE: if (t_exp) st_n = ST_PREA1;
         ST_PREA1: begin
            cmd           = CMD_PREA;
            addr_o[A_ALL] = 1'b1;
            t_load = 1'b1;  t_val = CNT_W'(TRP_CYC - 2);
            st_n   = ST_WAIT; ret_n = ST_EMRS;
         end
         ST_EMRS: begin
            cmd    = CMD_MODE;
            ba_o   = BA_W'(1);
            addr_o = EMR_OP & ~ADDR_W'(1);
            t_load = 1'b1;  t_val = CNT_W'(TMRD_CYC - 2);
            st_n   = ST_WAIT; ret_n = ST_MRS_DLL;
         end
         ST_MRS_DLL: begin
            cmd           = CMD_MODE;
            addr_o        = MR_OP;
            addr_o[A_DLL] = 1'b1;
            lk_start      = 1'b1;
            t_load = 1'b1;  t_val = CNT_W'(TMRD_CYC - 2);
            st_n   = ST_WAIT; ret_n = ST_PREA2;
         end
         ST_PREA2: begin
            cmd           = CMD_PREA;
            addr_o[A_ALL] = 1'b1;
            rleft_n       = RN_W'(REF_N - 1);
            t_load = 1'b1;  t_val = CNT_W'(TRP_CYC - 2);
            st_n   = ST_WAIT; ret_n = ST_REF;
         end
         ST_REF: begin
            cmd    = CMD_REF;
            t_load = 1'b1;  t_val = CNT_W'(TRFC_CYC - 2);
            st_n   = ST_WAIT;
            if (rleft == '0) ret_n = ST_MRS_FIN;
            else begin
               ret_n   = ST_REF;
               rleft_n = rleft - RN_W'(1);
            end
         end
         ST_MRS_FIN: begin
            cmd           = CMD_MODE;
            addr_o        = MR_OP;
            addr_o[A_DLL] = 1'b0;
            t_load        = 1'b1;
            if (lk_left > CNT_W'(TMRD_CYC - 1)) t_val = lk_left - CNT_W'(1);
            else                                t_val = CNT_W'(TMRD_CYC - 2);
            st_n   = ST_WAIT; ret_n = ST_DONE;
         end
         ST_WAIT: if (t_exp) st_n = ret;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= ST_IDLE;
         ret   <= ST_IDLE;
         rleft <= '0;
      end else begin
         st    <= st_n;
         ret   <= ret_n;
         rleft <= rleft_n;
      end
   end

   ddr_init_timer #(.W(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .load(t_load), .val(t_val),
      .cnt(t_cnt), .expired(t_exp));

   ddr_init_lock #(.W(CNT_W), .LOAD_VAL(LOCK_CYC - 2)) u_lock (
      .clk(clk), .rst(rst), .start(lk_start), .left(lk_left));

   ddr_init_cmd_enc u_enc (
      .cmd(cmd), .cs_n(cs_n_o), .ras_n(ras_n_o), .cas_n(cas_n_o), .we_n(we_n_o));

   assign cke_o  = (st != ST_IDLE);
   assign done_o = (st == ST_DONE);

   logic bus_nop, bus_mode, bus_ref;
   assign bus_nop  = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);
   assign bus_mode = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000);
   assign bus_ref  = ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001);

   // R1
   rst_idle_chk: assert property (@(posedge clk)
      rst |=> (!cke_o && cs_n_o && !done_o));

   // R10
   cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cke_o |=> cke_o);

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> done_o);

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> bus_nop);

   // R6
   mode_gap_chk: assert property (@(posedge clk) disable iff (rst)
      bus_mode |=> bus_nop);

   // R7
   ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
      bus_ref |=> bus_nop);

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic       cke [2];
   logic       dn  [2];
   logic [3:0] bus [2];
   logic [1:0] ba  [2];
   logic [11:0] ad [2];
   logic cs_a, ras_a, cas_a, we_a, cs_b, ras_b, cas_b, we_b;

   ddr_init_seq #(.STABLE_CYC(50), .TRP_CYC(3), .TMRD_CYC(2), .TRFC_CYC(7),
                  .REF_CNT(3), .LOCK_CYC(200), .EMR_OP(12'h003), .MR_OP(12'h062))
   u_ddr_init_seq (.clk(clk), .rst(rst), .cke_o(cke[0]), .cs_n_o(cs_a),
                   .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a),
                   .ba_o(ba[0]), .addr_o(ad[0]), .done_o(dn[0]));

   ddr_init_seq #(.STABLE_CYC(10), .TRP_CYC(2), .TMRD_CYC(4), .TRFC_CYC(5),
                  .REF_CNT(1), .LOCK_CYC(6), .EMR_OP(12'h000), .MR_OP(12'h122))
   u_ddr_init_seq_b (.clk(clk), .rst(rst), .cke_o(cke[1]), .cs_n_o(cs_b),
                     .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b),
                     .ba_o(ba[1]), .addr_o(ad[1]), .done_o(dn[1]));

   assign bus[0] = {cs_a, ras_a, cas_a, we_a};
   assign bus[1] = {cs_b, ras_b, cas_b, we_b};

   // {instance, cmd[3:0], ba[1:0], addr[11:0], gap[15:0]}
   localparam logic [34:0] EXP [15] = '{
      {1'b0, 4'b0010, 2'd0, 12'h400, 16'd50},  // R2 R3
      {1'b0, 4'b0000, 2'd1, 12'h002, 16'd3},   // R4
      {1'b0, 4'b0000, 2'd0, 12'h162, 16'd2},   // R5
      {1'b0, 4'b0010, 2'd0, 12'h400, 16'd2},   // R3
      {1'b0, 4'b0001, 2'd0, 12'h000, 16'd3},   // R7
      {1'b0, 4'b0001, 2'd0, 12'h000, 16'd7},   // R6
      {1'b0, 4'b0001, 2'd0, 12'h000, 16'd7},   // R7
      {1'b0, 4'b0000, 2'd0, 12'h062, 16'd7},   // R8
      {1'b1, 4'b0010, 2'd0, 12'h400, 16'd10},  // R2
      {1'b1, 4'b0000, 2'd1, 12'h000, 16'd2},   // R4
      {1'b1, 4'b0000, 2'd0, 12'h122, 16'd4},   // R5
      {1'b1, 4'b0010, 2'd0, 12'h400, 16'd4},   // R3
      {1'b1, 4'b0001, 2'd0, 12'h000, 16'd2},   // R7
      {1'b1, 4'b0001, 2'd0, 12'h000, 16'd5},   // R7 clamp
      {1'b1, 4'b0000, 2'd0, 12'h022, 16'd5}    // R8
   };
   localparam int EXP_N [2]    = '{8, 7};
   localparam int EXP_DONE [2] = '{255, 36};  // R9

   int checks = 0;
   int fails  = 0;
   logic mon_en = 1'b0;
   int cyc = 0;
   int evn [2], done_cyc [2], done_drop [2], cke_low [2];
   int ev_cyc [2][16];
   logic [17:0] ev_val [2][16];
   logic finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         for (int i = 0; i < 2; i++) begin
            if (!cke[i]) cke_low[i]++;
            if (bus[i] != 4'b0111) begin
               if (evn[i] < 16) begin
                  ev_cyc[i][evn[i]] = cyc;
                  ev_val[i][evn[i]] = {bus[i], ba[i], ad[i]};
               end
               evn[i]++;
            end
            if (dn[i] && done_cyc[i] < 0) done_cyc[i] = cyc;
            if (done_cyc[i] >= 0 && !dn[i]) done_drop[i]++;
         end
         cyc++;
      end
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         evn[i] = 0; done_cyc[i] = -1; done_drop[i] = 0; cke_low[i] = 0;
      end
      repeat (3) @(negedge clk);
      for (int i = 0; i < 2; i++)  // R1
         check(!cke[i] && bus[i] == 4'b1111 && !dn[i], "R1", "reset idle",
               {cke[i], bus[i], dn[i]}, 6'b011110);
      #2 rst = 1'b0;
      mon_en = 1'b1;
      wait (cyc >= 300);
      @(negedge clk);
      mon_en = 1'b0;
      begin
         int t [2];
         int k [2];
         t = '{0, 0};
         k = '{0, 0};
         for (int e = 0; e < 15; e++) begin
            int i;
            i = int'(EXP[e][34]);
            t[i] = t[i] + int'(EXP[e][15:0]);
            if (k[i] < 16)  // R6 spacing, R3 R4 R5 R7 R8 encodings
               check(ev_cyc[i][k[i]] == t[i] && ev_val[i][k[i]] == EXP[e][33:16],
                     "R6", $sformatf("inst %0d command %0d cycle/value", i, k[i]),
                     (ev_cyc[i][k[i]] << 20) | int'(ev_val[i][k[i]]),
                     (t[i] << 20) | int'(EXP[e][33:16]));
            k[i]++;
         end
      end
      for (int i = 0; i < 2; i++) begin
         check(evn[i] == EXP_N[i], "R7", "command count", evn[i], EXP_N[i]);
         check(done_cyc[i] == EXP_DONE[i], "R9", "done cycle", done_cyc[i], EXP_DONE[i]);
         check(done_drop[i] == 0, "R9", "done dropped", done_drop[i], 0);
         check(cke_low[i] == 0, "R10", "cke low cycles", cke_low[i], 0);
      end
      rst = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 2; i++)  // R1 reset after done
         check(!cke[i] && bus[i] == 4'b1111 && !dn[i], "R1", "re-reset idle",
               {cke[i], bus[i], dn[i]}, 6'b011110);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule